// File: doc/BRIEF.md
# Receive Control-Character Recognizer for a Byte-Synchronous Link

This block sits behind the byte assembler of a character-oriented synchronous receiver. For every received byte it decides whether the byte is a framing SYNC to strip, an ordinary data byte to store, or a control character that ends the current receive buffer. Control characters are defined by a table of up to eight entries. Each entry holds a character value, an end-of-table flag, a flag that defers the close until a check sequence has arrived, and a flag that asks for a return to hunt mode. A single shared mask selects which bit positions take part in every comparison.

A matching entry either closes the buffer at once or arms a wait for one or two check bytes and closes the buffer after the last of them. Every close caused by a control character raises an interrupt strobe. It also raises a hunt request when the entry asks for one. The buffer manager reacts to these strobes. Bit synchronization and computing the check sequence are handled elsewhere. For 7-bit characters with parity, the parity bit is simply part of the stored values.

Top module: `ctlchar_rx_recognizer`

## Requirements
- R1: After reset, all six strobes are low and no check-byte wait is pending.
- R2: A table entry matches when the received byte and the entry value agree in every bit position whose mask bit is 1. Positions with mask bit 0 are ignored.
- R3: Entries are examined from index 0 upward. The first entry whose end flag is 1 stops the scan, and neither that entry nor any later one can match.
- R4: When several examined entries match, the lowest index decides the action.
- R5: A match on an entry with defer flag 0 pulses wr_o, close_o and irq_o together.
- R6: A match on an entry with defer flag 1 pulses wr_o and bcs_wait_o. The block then waits for one check byte (bcs_two_i=0) or two (bcs_two_i=1), and pulses close_o and irq_o on the last of them.
- R7: Check bytes are not compared against the table, not written and not stripped as SYNC. They produce no strobe other than the close on the last one.
- R8: hunt_req_o pulses together with close_o when the deciding entry has hunt flag 1. For a deferred entry this happens on the last check byte.
- R9: When hunt_i is low, no check byte is pending, sync_en_i is 1 and the byte equals sync_char_i in all 8 bits, only discard_o pulses.
- R10: A byte that is not stripped and matches no examined entry pulses wr_o alone.
- R11: A byte received while hunt_i is high produces no strobe and leaves a pending check-byte wait unchanged.
- R12: soft_rst_i, sampled on a clock edge, cancels a pending check-byte wait and suppresses the strobes of a byte presented in that cycle.
- R13: Every strobe is a one-cycle pulse, registered one clock after the byte_vld_i cycle that caused it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| soft_rst_i | input | 1 | Synchronous clear of the check-byte wait |
| byte_vld_i | input | 1 | Received byte strobe |
| byte_i | input | 8 | Received byte |
| hunt_i | input | 1 | Receiver is hunting for synchronization |
| bcs_two_i | input | 1 | 1: two check bytes, 0: one check byte |
| sync_en_i | input | 1 | Enables SYNC stripping |
| sync_char_i | input | 8 | SYNC character value |
| mask_i | input | 8 | Shared compare mask, 1 = compare the bit |
| tbl_end_i | input | 8 | Per-entry end-of-table flag, bit i = entry i |
| tbl_defer_i | input | 8 | Per-entry defer-close flag |
| tbl_hunt_i | input | 8 | Per-entry hunt-request flag |
| tbl_char_i | input | 64 | Entry values, entry i in bits [8i+7:8i] |
| wr_o | output | 1 | Write byte to buffer |
| close_o | output | 1 | Close buffer |
| bcs_wait_o | output | 1 | Check-byte wait armed |
| hunt_req_o | output | 1 | Request hunt mode |
| discard_o | output | 1 | SYNC byte stripped |
| irq_o | output | 1 | Maskable interrupt event |

## Verification
The embedded assertions check on every cycle that each strobe follows a byte strobe, that a hunt request only comes with a close, that a stripped SYNC byte raises no other strobe, that at most one table entry wins, and that the wait counter arms and clears as commanded. Whether the right entry wins under masks, end flags and overlapping values, and whether one or two check bytes pass before the close, can only be shown by the bench's scenarios. The bench compares every strobe against a reference model over directed corner cases and seeded random tables and bytes.

// File: rtl/ctlchar_pkg.sv
package ctlchar_pkg;
  localparam int unsigned CHAR_W = 8;
  localparam int unsigned MAX_ENTRIES = 8;

  typedef struct packed {
    logic hit;
    logic defer;
    logic hunt;
  } match_t;
endpackage

// File: rtl/ctlchar_match.sv
module ctlchar_match
  import ctlchar_pkg::*;
#(
  parameter int unsigned N_ENTRIES = 8,
  parameter int unsigned W = CHAR_W
) (
  input  logic [W-1:0]           byte_i,
  input  logic [W-1:0]           mask_i,
  input  logic [N_ENTRIES-1:0]   end_i,
  input  logic [N_ENTRIES-1:0]   defer_i,
  input  logic [N_ENTRIES-1:0]   hunt_i,
  input  logic [N_ENTRIES*W-1:0] char_i,
  output match_t                 res_o
);
  logic [N_ENTRIES-1:0] eq, alive, cand, first;

  // per-entry masked compare and end-of-table propagation
  for (genvar g = 0; g < N_ENTRIES; g++) begin : g_ent
    assign eq[g] = ((byte_i ^ char_i[g*W +: W]) & mask_i) == '0;
    if (g == 0) begin : g_head
      assign alive[g] = ~end_i[g];
    end else begin : g_tail
      assign alive[g] = alive[g-1] & ~end_i[g];
    end
  end

  assign cand = eq & alive;

  always_comb begin
    first = '0;
    for (int i = N_ENTRIES - 1; i >= 0; i--) begin
      if (cand[i]) first = '0;
      if (cand[i]) first[i] = 1'b1;
    end
  end

  assign res_o.hit   = |first;
  assign res_o.defer = |(first & defer_i);
  assign res_o.hunt  = |(first & hunt_i);

  always_comb begin
    a_r4_single_winner: assert ($onehot0(first));
  end
endmodule

// File: rtl/ctlchar_bcs_track.sv
module ctlchar_bcs_track (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic start_i,
  input  logic two_i,
  input  logic hunt_i,
  input  logic consume_i,
  output logic waiting_o,
  output logic done_o,
  output logic done_hunt_o
);
  logic [1:0] cnt_q;
  logic       hunt_q;

  assign waiting_o   = cnt_q != 2'd0;
  assign done_o      = consume_i && cnt_q == 2'd1;
  assign done_hunt_o = done_o && hunt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= 2'd0;
      hunt_q <= 1'b0;
    end else if (clr_i) begin
      cnt_q  <= 2'd0;
      hunt_q <= 1'b0;
    end else if (start_i) begin
      cnt_q  <= two_i ? 2'd2 : 2'd1;
      hunt_q <= hunt_i;
    end else if (consume_i && waiting_o) begin
      cnt_q  <= cnt_q - 2'd1;
    end
  end

  a_r6_wait_armed: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !clr_i) |=> waiting_o);
  a_r12_wait_cleared: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> !waiting_o);
  a_r7_countdown: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (consume_i && !clr_i && cnt_q == 2'd2) |=> cnt_q == 2'd1);
endmodule

// File: rtl/ctlchar_rx_recognizer.sv
module ctlchar_rx_recognizer
  import ctlchar_pkg::*;
#(
  parameter int unsigned N_ENTRIES = MAX_ENTRIES,
  parameter int unsigned W = CHAR_W
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   soft_rst_i,
  input  logic                   byte_vld_i,
  input  logic [W-1:0]           byte_i,
  input  logic                   hunt_i,
  input  logic                   bcs_two_i,
  input  logic                   sync_en_i,
  input  logic [W-1:0]           sync_char_i,
  input  logic [W-1:0]           mask_i,
  input  logic [N_ENTRIES-1:0]   tbl_end_i,
  input  logic [N_ENTRIES-1:0]   tbl_defer_i,
  input  logic [N_ENTRIES-1:0]   tbl_hunt_i,
  input  logic [N_ENTRIES*W-1:0] tbl_char_i,
  output logic                   wr_o,
  output logic                   close_o,
  output logic                   bcs_wait_o,
  output logic                   hunt_req_o,
  output logic                   discard_o,
  output logic                   irq_o
);
  match_t m;
  logic   evt, waiting, done, done_hunt, start, strip;
  logic   wr_d, close_d, bw_d, hunt_d, disc_d;

  ctlchar_match #(.N_ENTRIES(N_ENTRIES), .W(W)) i_match (
    .byte_i (byte_i),
    .mask_i (mask_i),
    .end_i  (tbl_end_i),
    .defer_i(tbl_defer_i),
    .hunt_i (tbl_hunt_i),
    .char_i (tbl_char_i),
    .res_o  (m)
  );

  assign evt   = byte_vld_i && !hunt_i && !soft_rst_i;
  assign strip = sync_en_i && byte_i == sync_char_i;
  assign start = evt && !waiting && !strip && m.hit && m.defer;

  ctlchar_bcs_track i_track (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .clr_i      (soft_rst_i),
    .start_i    (start),
    .two_i      (bcs_two_i),
    .hunt_i     (m.hunt),
    .consume_i  (evt && waiting),
    .waiting_o  (waiting),
    .done_o     (done),
    .done_hunt_o(done_hunt)
  );

  // check bytes take precedence over stripping and table lookup
  always_comb begin
    wr_d = 1'b0; close_d = 1'b0; bw_d = 1'b0; hunt_d = 1'b0; disc_d = 1'b0;
    if (evt) begin
      if (waiting) begin
        close_d = done;
        hunt_d  = done_hunt;
      end else if (strip) begin
        disc_d = 1'b1;
      end else begin
        wr_d = 1'b1;
        if (m.hit && m.defer) begin
          bw_d = 1'b1;
        end else if (m.hit) begin
          close_d = 1'b1;
          hunt_d  = m.hunt;
        end
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_o <= 1'b0; close_o <= 1'b0; bcs_wait_o <= 1'b0;
      hunt_req_o <= 1'b0; discard_o <= 1'b0; irq_o <= 1'b0;
    end else begin
      wr_o       <= wr_d;
      close_o    <= close_d;
      bcs_wait_o <= bw_d;
      hunt_req_o <= hunt_d;
      discard_o  <= disc_d;
      irq_o      <= close_d;
    end
  end

  a_r13_strobe_follows_byte: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_o || close_o || discard_o || bcs_wait_o) |-> $past(byte_vld_i && !hunt_i));
  a_r8_hunt_with_close: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hunt_req_o |-> close_o && irq_o);
  a_r9_discard_alone: assert property (@(posedge clk_i) disable iff (!rst_ni)
    discard_o |-> !(wr_o || close_o || bcs_wait_o || hunt_req_o));
  a_r11_hunt_silent: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(hunt_i) |-> !(wr_o || close_o || discard_o || bcs_wait_o));
endmodule

// File: tb/test_ctlchar_rx_recognizer.sv
module test_ctlchar_rx_recognizer;
  localparam int CLK_PERIOD = 10;
  localparam int N = 8;

  logic clk = 1'b0, rst_n = 1'b0;
  logic soft_rst = 0, vld = 0, hunt = 0, two = 0, sync_en = 0;
  logic [7:0] bval = 0, sync_c = 8'h16, mask = 8'hff;
  logic [N-1:0] t_end = '0, t_def = '0, t_hnt = '0;
  logic [N*8-1:0] t_chr = '0;
  logic wr, cl, bw, hr, dc, iq;

  int checks = 0, fails = 0;
  int m_cnt = 0;
  logic m_hp = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ctlchar_rx_recognizer i_ctlchar_rx_recognizer (
    .clk_i(clk), .rst_ni(rst_n), .soft_rst_i(soft_rst), .byte_vld_i(vld),
    .byte_i(bval), .hunt_i(hunt), .bcs_two_i(two), .sync_en_i(sync_en),
    .sync_char_i(sync_c), .mask_i(mask), .tbl_end_i(t_end),
    .tbl_defer_i(t_def), .tbl_hunt_i(t_hnt), .tbl_char_i(t_chr),
    .wr_o(wr), .close_o(cl), .bcs_wait_o(bw), .hunt_req_o(hr),
    .discard_o(dc), .irq_o(iq));

  initial begin : watchdog
    #(CLK_PERIOD * 150000);
    fails++; checks++;
    $display("FAIL watchdog expired: actual hung, expected finish");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  // reference model: returns {wr,close,bcs_wait,hunt_req,discard,irq}
  function automatic logic [5:0] model(input logic v, input logic [7:0] b);
    logic [5:0] e = '0;
    logic stop = 0, found = 0;
    if (soft_rst) begin
      m_cnt = 0; m_hp = 0;
      return e;
    end
    if (!v || hunt) return e;
    if (m_cnt != 0) begin
      if (m_cnt == 1) begin e[4] = 1; e[0] = 1; e[2] = m_hp; end
      m_cnt--;
      return e;
    end
    if (sync_en && b == sync_c) begin e[1] = 1; return e; end
    e[5] = 1;
    for (int i = 0; i < N; i++) begin
      if (t_end[i]) stop = 1;
      if (!stop && !found && (((b ^ t_chr[i*8 +: 8]) & mask) == 8'h00)) begin
        found = 1;
        if (t_def[i]) begin e[3] = 1; m_cnt = two ? 2 : 1; m_hp = t_hnt[i]; end
        else begin e[4] = 1; e[0] = 1; e[2] = t_hnt[i]; end
      end
    end
    return e;
  endfunction

  task automatic check(input string tag, input logic [5:0] exp);
    logic [5:0] act = {wr, cl, bw, hr, dc, iq};
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual wr,cl,bw,hr,dc,iq=%b expected %b", tag, act, exp);
    end
  endtask

  task automatic step(input logic v, input logic [7:0] b, input string tag);
    logic [5:0] e;
    vld = v; bval = b;
    e = model(v, b);
    @(negedge clk);
    check(tag, e);
    vld = 0; soft_rst = 0;
  endtask

  task automatic set_ent(input int i, input logic [7:0] c, input logic e,
                         input logic d, input logic h);
    t_chr[i*8 +: 8] = c; t_end[i] = e; t_def[i] = d; t_hnt[i] = h;
  endtask

  initial begin
    int unsigned seed = 32'h5eed_0017;
    void'($urandom(seed));
    repeat (3) @(negedge clk);
    check("R1 during reset", 6'b0);
    rst_n = 1;
    @(negedge clk);
    check("R1 after reset", 6'b0);

    for (int i = 0; i < N; i++) set_ent(i, 8'h80 + 8'(i), 0, 0, 0);
    step(1, 8'h41, "R10 plain data");
    step(1, 8'h82, "R5 immediate close");
    mask = 8'h0f;
    step(1, 8'hf3, "R2 masked upper bits");
    mask = 8'hff;
    step(1, 8'hf3, "R2 full mask no hit");
    t_end[2] = 1;
    step(1, 8'h83, "R3 entry beyond end");
    step(1, 8'h82, "R3 end entry itself");
    step(1, 8'h81, "R3 entry before end");
    t_end = '0;
    set_ent(1, 8'h55, 0, 1, 1); set_ent(4, 8'h55, 0, 0, 0);
    two = 1;
    step(1, 8'h55, "R4 lowest index defers");
    step(1, 8'h55, "R7 first check byte not compared");
    step(1, 8'h99, "R6 R8 close after two bytes");
    two = 0;
    step(1, 8'h55, "R6 arm one-byte wait");
    hunt = 1;
    step(1, 8'h12, "R11 byte while hunting");
    hunt = 0;
    sync_en = 1;
    step(1, 8'h16, "R7 check byte equal to SYNC");
    step(1, 8'h16, "R9 SYNC stripped");
    sync_en = 0;
    set_ent(0, 8'h03, 0, 0, 1);
    step(1, 8'h03, "R8 immediate hunt");
    step(1, 8'h55, "R12 arm wait");
    soft_rst = 1;
    step(1, 8'h00, "R12 soft reset");
    step(1, 8'h80, "R12 wait cancelled");
    step(0, 8'h80, "R13 idle");

    for (int k = 0; k < 3000; k++) begin
      if (k % 200 == 0) begin
        for (int i = 0; i < N; i++)
          set_ent(i, 8'h10 | 8'($urandom_range(0, 7)), $urandom_range(0, 9) == 0,
                  $urandom_range(0, 2) == 0, $urandom_range(0, 3) == 0);
        mask    = ($urandom_range(0, 3) == 0) ? 8'($urandom) | 8'hf0 : 8'hff;
        two     = 1'($urandom);
        sync_en = 1'($urandom);
        sync_c  = 8'h16;
      end
      hunt     = $urandom_range(0, 15) == 0;
      soft_rst = $urandom_range(0, 63) == 0;
      step($urandom_range(0, 3) != 0, 8'h10 | 8'($urandom_range(0, 7)) |
           (($urandom_range(0, 7) == 0) ? 8'h40 : 8'h00), "R13 random");
      hunt = 0;
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule